// File: doc/BRIEF.md
# Serial Transmit Channel with Deferred Shutdown

This block is the transmit half of an asynchronous serial port. Software places one character at a time into a holding register. The character moves into a shift register as soon as that register is free, and the shift register drives it onto the line. A start bit comes first, then the data bits with the least significant bit first, then an optional parity bit, then a stop period. The stop period is set in sixteenths of a bit, so fractional stop lengths are possible. Baud generation sits outside the block. The block advances only on a 16x oversampling enable pulse, `tick16`.

A four-bit command write controls the channel. One write can carry several commands: enable, disable, reset, and assert request-to-send. A write that combines enable with disable, or enable with reset, is rejected as a whole. When the shutdown-on-drain mode is set, a disable command does not take effect at once. It waits until the holding register and the shift register have both emptied, stop period included. At that point the channel disables itself and negates request-to-send, so the far end sees when the message has ended. A ready flag reports that the holding register can take a character, and a mask can route that flag to an interrupt line.

Top module: `serial_tx_chan`

## Requirements
- R1: After reset, `txd`=1, `tx_ready`=0, `irq`=0, `rts`=0 and `tx_empty`=1.
- R2: A frame is a start bit (0), then DATA_W data bits with the least significant bit first, then a parity bit if `par_en`=1, then a stop level of 1. Each bit lasts 16 `tick16` pulses. The parity bit is the XOR of the data bits, inverted when `par_odd`=1, so `par_odd`=0 gives even parity. The line rests at 1 when no frame is being sent.
- R3: The stop level lasts `stop_ticks` pulses of `tick16`, with 0 treated as 1. When characters are sent back to back, consecutive start bits are 16·(1+DATA_W+par_en)+`stop_ticks` ticks apart. For example, 13 ticks gives a stop of 0.813 bits.
- R4: A data write is accepted only while `tx_ready`=1. A write made while the channel is disabled, or while the holding register is full, has no effect.
- R5: `tx_ready` is 1 only when the channel is enabled, no disable is pending and the holding register is empty. `irq` equals `tx_ready` gated by `irq_en`.
- R6: When `auto_off`=0, disable (command bit 1) takes effect on the next clock. A character already in the shift register finishes. A character in the holding register is kept and is sent after the next enable (command bit 0).
- R7: When `auto_off`=1, a disable issued while data is buffered is held pending and `tx_ready` reads 0. Both registers drain fully, stop period included, before the channel disables.
- R8: Command bit 3 sets `rts`. When a pending shutdown completes, `rts` is cleared on the clock after `tx_empty` rises.
- R9: When `auto_off`=1 and the channel is already drained (underrun), a disable completes on the accepting clock: `rts` and `tx_ready` read 0 at the next sample.
- R10: Reset (command bit 2) returns the line to 1 on the next clock. It also clears `tx_ready`, discards a held character, disables the channel and cancels a pending shutdown.
- R11: A command write that sets bit 0 together with bit 1 or bit 2 is ignored in full.
- R12: Without `tick16` pulses, a frame in progress does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | 16x bit-rate enable pulse |
| cmd_wr | input | 1 | Command write strobe |
| cmd_bits | input | 4 | Commands: bit0 enable, bit1 disable, bit2 reset, bit3 assert rts |
| data_wr | input | 1 | Character write strobe |
| data_in | input | DATA_W | Character to send |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_ticks | input | STOP_W | Stop length in tick16 pulses |
| auto_off | input | 1 | Defer disable until drained |
| irq_en | input | 1 | Route ready to irq |
| txd | output | 1 | Serial line |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Both registers empty |
| irq | output | 1 | Ready interrupt |
| rts | output | 1 | Request-to-send |

## Verification
Commands and data writes are registered, so their effects on `tx_ready`, `rts` and `txd` appear at the falling edge after the strobe, and the bench samples there. The negation of `rts` after a deferred shutdown comes one clock after `tx_empty` rises, and the bench checks both of those falling edges. Serial bits are sampled near mid-bit, counted in clocks from the detected start edge. Frame spacing is measured only between the second and third of three back-to-back frames, because only then do both starts fall on a tick boundary.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_e;

    // bit0 enable, bit1 disable, bit2 reset, bit3 assert rts
    typedef struct packed {
        logic rts_on;
        logic clear;
        logic halt;
        logic go;
    } tx_cmd_t;

endpackage

// File: rtl/serial_tx_hold.sv
module serial_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              accept,
    input  logic              take,
    input  logic              flush,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) hold_d.valid = 1'b0;
        if (wr && accept) begin
            hold_d.valid = 1'b1;
            hold_d.data  = wr_data;
        end
        if (flush) hold_d.valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign valid = hold_q.valid;
    assign data  = hold_q.data;

    // R4: a held character is never replaced before it is taken
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q.valid && !take && !flush) |=> (hold_q.valid && $stable(hold_q.data)));

endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter
    import serial_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16,
    parameter int STOP_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              flush,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [STOP_W-1:0] stop_ticks,
    output logic              ld_take,
    output logic              busy,
    output logic              txd
);

    localparam int STOP_MAX = 1 << STOP_W;
    localparam int CNT_MAX  = (OS_RATE > STOP_MAX) ? OS_RATE : STOP_MAX;
    localparam int CNT_W    = $clog2(CNT_MAX);
    localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] OS_LAST  = CNT_W'(OS_RATE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        tx_phase_e         phase;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              par;
    } shift_t;

    shift_t sh_d, sh_q;
    logic [CNT_W-1:0] stop_last;
    logic             do_load;

    always_comb begin
        stop_last = (stop_ticks == '0) ? '0 : (CNT_W'(stop_ticks) - CNT_W'(1));
    end

    always_comb begin
        sh_d    = sh_q;
        do_load = 1'b0;
        ld_take = 1'b0;
        case (sh_q.phase)
            PH_IDLE: do_load = ld_valid;
            PH_STOP: begin
                if (tick) begin
                    if (sh_q.cnt == stop_last) begin
                        if (ld_valid) do_load = 1'b1;
                        else          sh_d.phase = PH_IDLE;
                    end else begin
                        sh_d.cnt = sh_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (sh_q.cnt == OS_LAST) begin
                        sh_d.cnt = '0;
                        case (sh_q.phase)
                            PH_START: begin
                                sh_d.phase = PH_DATA;
                                sh_d.idx   = '0;
                            end
                            PH_DATA: begin
                                if (sh_q.idx == IDX_LAST) begin
                                    sh_d.phase = par_en ? PH_PARITY : PH_STOP;
                                end else begin
                                    sh_d.idx = sh_q.idx + IDX_W'(1);
                                    sh_d.sh  = sh_q.sh >> 1;
                                end
                            end
                            PH_PARITY: sh_d.phase = PH_STOP;
                            default:   sh_d.phase = PH_IDLE;
                        endcase
                    end else begin
                        sh_d.cnt = sh_q.cnt + CNT_W'(1);
                    end
                end
            end
        endcase
        if (do_load) begin
            sh_d.phase = PH_START;
            sh_d.cnt   = '0;
            sh_d.idx   = '0;
            sh_d.sh    = ld_data;
            sh_d.par   = (^ld_data) ^ par_odd;
            ld_take    = 1'b1;
        end
        if (flush) begin
            sh_d.phase = PH_IDLE;
            sh_d.cnt   = '0;
            ld_take    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            sh_q.phase <= PH_IDLE;
        end else begin
            sh_q <= sh_d;
        end
    end

    always_comb begin
        case (sh_q.phase)
            PH_START:  txd = 1'b0;
            PH_DATA:   txd = sh_q.sh[0];
            PH_PARITY: txd = sh_q.par;
            default:   txd = 1'b1;
        endcase
    end

    assign busy = (sh_q.phase != PH_IDLE);

    // R12: no tick, no progress inside a frame
    a_r12_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !flush) |=> ($stable(sh_q.phase) && $stable(sh_q.cnt)));

    // R10: a flush always leaves the shifter idle
    a_r10_flush_idles: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (sh_q.phase == PH_IDLE));

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
    import serial_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_wr,
    input  tx_cmd_t cmd,
    input  logic    auto_off,
    input  logic    drained,
    output logic    en,
    output logic    pend,
    output logic    rts,
    output logic    flush
);

    typedef struct packed {
        logic en;
        logic pend;
        logic rts;
    } ctrl_t;

    ctrl_t ct_d, ct_q;
    logic  accept;

    always_comb begin
        ct_d   = ct_q;
        flush  = 1'b0;
        accept = cmd_wr && !(cmd.go && (cmd.clear || cmd.halt));
        if (accept) begin
            if (cmd.clear) begin
                ct_d.en   = 1'b0;
                ct_d.pend = 1'b0;
                flush     = 1'b1;
            end
            if (cmd.go) begin
                ct_d.en   = 1'b1;
                ct_d.pend = 1'b0;
            end
            if (cmd.halt) begin
                if (auto_off && ct_d.en) begin
                    ct_d.pend = 1'b1;
                end else begin
                    ct_d.en   = 1'b0;
                    ct_d.pend = 1'b0;
                end
            end
            if (cmd.rts_on) ct_d.rts = 1'b1;
        end
        if (ct_d.pend && drained) begin
            ct_d.en   = 1'b0;
            ct_d.pend = 1'b0;
            ct_d.rts  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    assign en   = ct_q.en;
    assign pend = ct_q.pend;
    assign rts  = ct_q.rts;

    // R7: a pending shutdown only exists on an enabled channel
    a_r7_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        ct_q.pend |-> ct_q.en);

    // R11: enable combined with disable or reset leaves the enable state alone
    a_r11_conflict_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd.go && (cmd.clear || cmd.halt) && !ct_q.pend) |=> $stable(ct_q.en));

    // R9: disable in shutdown-on-drain mode while drained completes at once
    a_r9_underrun_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd.halt && !cmd.go && auto_off && drained) |=> (!ct_q.en && !ct_q.rts));

endmodule

// File: rtl/serial_tx_chan.sv
module serial_tx_chan
    import serial_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16,
    parameter int STOP_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              cmd_wr,
    input  logic [3:0]        cmd_bits,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [STOP_W-1:0] stop_ticks,
    input  logic              auto_off,
    input  logic              irq_en,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              irq,
    output logic              rts
);

    tx_cmd_t           cmd;
    logic              en, pend, flush;
    logic              hold_valid, ld_take, busy;
    logic [DATA_W-1:0] hold_data;

    assign cmd = tx_cmd_t'(cmd_bits);

    serial_tx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd      (cmd),
        .auto_off (auto_off),
        .drained  (tx_empty),
        .en       (en),
        .pend     (pend),
        .rts      (rts),
        .flush    (flush)
    );

    serial_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (data_wr),
        .wr_data (data_in),
        .accept  (tx_ready),
        .take    (ld_take),
        .flush   (flush),
        .valid   (hold_valid),
        .data    (hold_data)
    );

    serial_tx_shifter #(.DATA_W(DATA_W), .OS_RATE(OS_RATE), .STOP_W(STOP_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .flush      (flush),
        .ld_valid   (hold_valid && en),
        .ld_data    (hold_data),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .stop_ticks (stop_ticks),
        .ld_take    (ld_take),
        .busy       (busy),
        .txd        (txd)
    );

    assign tx_ready = en && !pend && !hold_valid;
    assign tx_empty = !hold_valid && !busy;
    assign irq      = tx_ready && irq_en;

    // R6: a disabled channel never starts a character
    a_r6_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !busy);

    // R8: rts falls only through a completed shutdown or never
    a_r8_rts_fall_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts) |-> (tx_empty && !en));

endmodule

// File: tb/serial_tx_chan_test.sv
module serial_tx_chan_test;
    localparam int CLK_PERIOD = 10;
    localparam int BITC = 32; // clocks per bit with tick16 every other clock

    logic       clk = 0, rst_n = 0, tick16 = 0, tick_run = 1;
    logic       cmd_wr = 0, data_wr = 0, par_en = 0, par_odd = 0, auto_off = 0, irq_en = 0;
    logic [3:0] cmd_bits = 0;
    logic [7:0] data_in = 0;
    logic [5:0] stop_ticks = 6'd16;
    logic       txd, tx_ready, tx_empty, irq, rts;

    int n_chk = 0, n_fail = 0, cyc = 0, last_start = -1, last_gap = 0;
    bit mon_on = 1, done = 0;
    logic [7:0] exp_q[$];

    serial_tx_chan uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    initial forever begin @(posedge clk); cyc++; end
    initial forever begin @(negedge clk); tick16 = tick_run ? ~tick16 : 1'b0; end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [3:0] v);
        @(negedge clk); cmd_bits = v; cmd_wr = 1;
        @(negedge clk); cmd_wr = 0;
    endtask

    task automatic raw_wr(input logic [7:0] b);
        @(negedge clk); data_in = b; data_wr = 1;
        @(negedge clk); data_wr = 0;
    endtask

    task automatic send(input logic [7:0] b);
        while (!tx_ready) @(negedge clk);
        exp_q.push_back(b);
        raw_wr(b);
    endtask

    task automatic drain();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: scoreboard of serial frames
    initial begin
        logic prev = 1;
        forever begin
            @(negedge clk);
            if (mon_on && prev && !txd) begin
                logic [7:0] got; logic [7:0] e; logic pbit;
                if (last_start >= 0) last_gap = cyc - last_start;
                last_start = cyc;
                repeat (BITC/2) @(negedge clk);
                chk(txd == 0, "R2 start bit", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    got[i] = txd;
                end
                if (par_en) begin repeat (BITC) @(negedge clk); pbit = txd; end
                repeat (BITC/2 + int'(stop_ticks)) @(negedge clk);
                chk(txd == 1, "R3 stop level", txd, 1);
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected frame", got, -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e, "R2 data", got, e);
                    if (par_en) chk(pbit == ((^e) ^ par_odd), "R2 parity", pbit, (^e) ^ par_odd);
                end
            end
            prev = txd;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lows;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(txd == 1, "R1 txd", txd, 1);
        chk(tx_ready == 0, "R1 ready", tx_ready, 0);
        chk(irq == 0 && rts == 0, "R1 irq/rts", {irq, rts}, 0);
        chk(tx_empty == 1, "R1 empty", tx_empty, 1);
        rst_n = 1;
        // R4 write while disabled is ignored
        raw_wr(8'h55);
        chk(tx_ready == 0 && tx_empty == 1, "R4 disabled write", {tx_ready, tx_empty}, 1);
        irq_en = 1;
        cmd(4'b0001);
        chk(tx_ready == 1, "R4 enable ready", tx_ready, 1);
        chk(irq == 1, "R5 irq", irq, 1);
        repeat (400) @(negedge clk);
        chk(txd == 1, "R4 idle line", txd, 1);
        // R2/R3 frames, 16-tick stop
        send(8'hA5); send(8'h3C); send(8'hC3);
        drain();
        chk(last_gap == 2*(144+16), "R3 gap stop16", last_gap, 2*(144+16));
        // R3 fractional stop of 13 ticks
        stop_ticks = 6'd13;
        send(8'h01); send(8'h80); send(8'h7E);
        drain();
        chk(last_gap == 2*(144+13), "R3 gap stop13", last_gap, 2*(144+13));
        stop_ticks = 6'd16;
        // R2 parity even and odd
        par_en = 1; send(8'h07); drain();
        par_odd = 1; send(8'h0F); send(8'h10); drain();
        par_en = 0; par_odd = 0;
        // R4 write while holding full
        send(8'h11); send(8'h22);
        chk(tx_ready == 0, "R5 ready low when full", tx_ready, 0);
        raw_wr(8'h33);
        drain();
        chk(exp_q.size() == 0, "R4 full write ignored", exp_q.size(), 0);
        // R6 immediate disable keeps held character
        send(8'h44); send(8'h66);
        cmd(4'b0010);
        chk(tx_ready == 0, "R6 ready after disable", tx_ready, 0);
        repeat (800) @(negedge clk);
        chk(tx_empty == 0, "R6 held kept", tx_empty, 0);
        chk(exp_q.size() == 1, "R6 shifter finished", exp_q.size(), 1);
        cmd(4'b0001);
        drain();
        chk(exp_q.size() == 0, "R6 held sent after enable", exp_q.size(), 0);
        // R7/R8 deferred shutdown
        auto_off = 1;
        cmd(4'b1000);
        chk(rts == 1, "R8 rts set", rts, 1);
        send(8'h5A); send(8'hA6);
        cmd(4'b0010);
        chk(tx_ready == 0 && rts == 1, "R7 pending", {tx_ready, rts}, 1);
        while (!tx_empty) @(negedge clk);
        chk(rts == 1, "R8 rts before drop", rts, 1);
        chk(exp_q.size() == 0, "R7 both drained", exp_q.size(), 0);
        @(negedge clk);
        chk(rts == 0, "R8 rts dropped", rts, 0);
        chk(tx_ready == 0, "R7 disabled after drain", tx_ready, 0);
        // R9 underrun shutdown
        cmd(4'b1001);
        chk(tx_ready == 1 && rts == 1, "R9 setup", {tx_ready, rts}, 3);
        cmd(4'b0010);
        chk(rts == 0 && tx_ready == 0, "R9 immediate", {rts, tx_ready}, 0);
        auto_off = 0;
        // R11 conflicts
        cmd(4'b0101);
        chk(tx_ready == 0, "R11 enable+reset", tx_ready, 0);
        cmd(4'b0011);
        chk(tx_ready == 0, "R11 enable+disable", tx_ready, 0);
        cmd(4'b0001);
        cmd(4'b0011);
        chk(tx_ready == 1, "R11 rejected while enabled", tx_ready, 1);
        // R10 reset mid frame
        mon_on = 0;
        raw_wr(8'h00); raw_wr(8'h00);
        repeat (100) @(negedge clk);
        cmd(4'b0100);
        chk(txd == 1, "R10 line idle", txd, 1);
        chk(tx_ready == 0 && tx_empty == 1, "R10 cleared", {tx_ready, tx_empty}, 1);
        lows = 0;
        repeat (400) begin @(negedge clk); if (!txd) lows++; end
        chk(lows == 0, "R10 no output", lows, 0);
        cmd(4'b0001);
        chk(tx_ready == 1 && tx_empty == 1, "R10 held discarded", {tx_ready, tx_empty}, 3);
        // R12 no tick no progress
        tick_run = 0;
        raw_wr(8'hFF);
        repeat (2) @(negedge clk);
        chk(txd == 0, "R12 start", txd, 0);
        repeat (100) @(negedge clk);
        chk(txd == 0, "R12 frozen", txd, 0);
        tick_run = 1;
        drain();
        // R5 irq mask
        irq_en = 0; @(negedge clk);
        chk(irq == 0 && tx_ready == 1, "R5 irq masked", {irq, tx_ready}, 1);
        irq_en = 1; @(negedge clk);
        chk(irq == 1, "R5 irq routed", irq, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule